// File: doc/BRIEF.md
# SPI Slave CRC-Checked Frame Transceiver

This block is an SPI slave that trades one fixed 40-bit frame with the master per chip-select window. Inbound, it collects four payload bytes followed by a CRC-8 byte and checks that trailer against the payload. Outbound, over the same clocks, it shifts out a 32-bit word supplied by the local logic, followed by a CRC-8 byte it computes over that word.

Each frame ends in one result on the local side: a status code, the received word and a valid flag. The flag stays up until the local side acknowledges it. A frame that stops before 40 bits while chip select stays low is closed by a timeout. Clocks beyond the 40th bit are tolerated. The SPI pins are brought into the system clock domain through two-flop synchronisers, and all edges are detected there.

Top module: `crcframe_slave`

## Requirements
- R1: A frame is 40 bits sent MSB first, sampled on falling SCLK edges (clock idles high). The first 32 bits form the word big-endian, with the first wire bit as bit 31. If bits 33..40 equal the CRC-8 of the word (polynomial 0x07, initial 0x00, no reflection, no final XOR, bits fed MSB first), the result has status 0x00 and carries the word. The result is held with `res_valid` high until a cycle with `res_ack` high.
- R2: If the trailer does not match, the status is 0x01 and `res_word` is zero.
- R3: MISO carries the loaded transmit word MSB first, then the CRC-8 of that word. Its first bit is present as soon as `cs_n` falls, and each following bit appears after a rising SCLK edge.
- R4: MISO is driven high while `cs_n` is high, and after the 40th bit it shifts out ones.
- R5: SCLK edges beyond the 40th within one chip-select window produce no further result. The status is decided by the first 40 bits only.
- R6: If `cs_n` stays low and between 1 and 39 bits have arrived `TIMEOUT_CYCLES` clocks after the first SCLK edge, the result is status 0x0B with a zero word.
- R7: If `cs_n` rises before the 40th bit, the partial frame is dropped with no result, and the next frame starts again from bit 0.
- R8: If a frame ends while the previous result is still valid and not acknowledged in that cycle, the result becomes status 0x03 with a zero word. The only status codes are 0x00, 0x01, 0x03 and 0x0B.
- R9: `tx_load` captures `tx_word`. A load made during a frame takes effect from the next frame onward.
- R10: After reset, `res_valid` is 0, `res_status` is 0x00 and `res_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock from the master, idle high |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, high while deselected |
| tx_word | input | 32 | Word to send in later frames |
| tx_load | input | 1 | Captures `tx_word` |
| res_valid | output | 1 | A result is pending |
| res_status | output | 8 | Frame status code |
| res_word | output | 32 | Received word, zero unless status is 0x00 |
| res_ack | input | 1 | Acknowledges and clears the pending result |

## Verification
A table of frames pairs inbound words with outbound words. The entries include all-zero and all-one words and words with one bit set at each end. Some entries carry a good trailer and some a corrupted one. The table separates CRC acceptance from rejection and shows whether the outbound word and its trailer leave in the right bit order. Directed frames then send 44 bits with good and with bad trailers (surplus tolerance), stop at 20 bits with select held low (timeout) or released (silent drop), and send two frames with no acknowledge between them (overrun). A load is made in the middle of a frame to show that it takes effect only from the next frame.

// File: rtl/crcframe_pkg.sv
`timescale 1ns/1ps
package crcframe_pkg;
    localparam int unsigned PAY_W   = 32;
    localparam int unsigned CRC_W   = 8;
    localparam int unsigned FRAME_W = PAY_W + CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [7:0] {
        ST_OK       = 8'h00,
        ST_CRC_BAD  = 8'h01,
        ST_OVERRUN  = 8'h03,
        ST_SHORT    = 8'h0B
    } status_e;

    // Bit-serial CRC-8, word fed MSB first, start value zero.
    function automatic logic [CRC_W-1:0] crc8_word(input logic [PAY_W-1:0] w);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ w[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction
endpackage

// File: rtl/crcframe_sync.sv
`timescale 1ns/1ps
module crcframe_sync #(
    parameter int unsigned N = 3,
    parameter logic [N-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= INIT[g];
                s2 <= INIT[g];
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/crcframe_timer.sv
`timescale 1ns/1ps
module crcframe_timer #(
    parameter int unsigned LIMIT = 44000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic          armed;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            armed  <= 1'b0;
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (start) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed) begin
                if (cnt == LAST) begin
                    armed  <= 1'b0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/crcframe_shifter.sv
`timescale 1ns/1ps
module crcframe_shifter
    import crcframe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_act,
    input  logic               sclk_fall,
    input  logic               sclk_rise,
    input  logic               mosi_b,
    input  logic               kill,
    input  logic [PAY_W-1:0]   load_word,
    output logic               tx_msb,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               first_edge,
    output logic               last_bit,
    output logic               frame_done
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] tx_sh;

    assign first_edge = cs_act && sclk_fall && (cnt == '0);
    assign last_bit   = cs_act && sclk_fall && !kill && (cnt == LAST);
    assign tx_msb     = tx_sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            rx_frame   <= '0;
            tx_sh      <= '1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!cs_act) begin
                cnt   <= '0;
                tx_sh <= {load_word, crc8_word(load_word)};
            end else begin
                if (kill) begin
                    cnt <= FULL;
                end else if (sclk_fall && cnt < FULL) begin
                    rx_frame <= {rx_frame[FRAME_W-2:0], mosi_b};
                    cnt      <= cnt + 1'b1;
                    if (cnt == LAST) frame_done <= 1'b1;
                end
                if (sclk_rise) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b1};
            end
        end
    end
endmodule

// File: rtl/crcframe_slave.sv
`timescale 1ns/1ps
module crcframe_slave
    import crcframe_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 44000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    input  logic [31:0] tx_word,
    input  logic        tx_load,
    output logic        res_valid,
    output logic [7:0]  res_status,
    output logic [31:0] res_word,
    input  logic        res_ack
);
    logic [2:0]         pins_s;
    logic               sclk_s, cs_s, mosi_s, sclk_d;
    logic               sclk_fall, sclk_rise, cs_act;
    logic [PAY_W-1:0]   tx_reg;
    logic               tx_msb, first_edge, last_bit, frame_done, tmo_hit;
    logic [FRAME_W-1:0] rx_frame;
    logic               crc_ok;
    status_e            st_q;
    logic [PAY_W-1:0]   word_q;

    crcframe_sync #(.N(3), .INIT(3'b110)) u_sync (
        .clk(clk), .rst(rst), .d({sclk, cs_n, mosi}), .q(pins_s)
    );
    assign {sclk_s, cs_s, mosi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b1;
        else     sclk_d <= sclk_s;
    end
    assign cs_act    = !cs_s;
    assign sclk_fall = sclk_d && !sclk_s;
    assign sclk_rise = !sclk_d && sclk_s;

    always_ff @(posedge clk) begin
        if (rst)          tx_reg <= '0;
        else if (tx_load) tx_reg <= tx_word;
    end

    crcframe_shifter u_shift (
        .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
        .sclk_rise(sclk_rise), .mosi_b(mosi_s), .kill(tmo_hit),
        .load_word(tx_reg), .tx_msb(tx_msb), .rx_frame(rx_frame),
        .first_edge(first_edge), .last_bit(last_bit), .frame_done(frame_done)
    );

    crcframe_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(first_edge),
        .stop(last_bit || !cs_act), .expire(tmo_hit)
    );

    assign miso   = cs_n ? 1'b1 : tx_msb;
    assign crc_ok = crc8_word(rx_frame[FRAME_W-1:CRC_W]) == rx_frame[CRC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            st_q      <= ST_OK;
            word_q    <= '0;
        end else begin
            if (res_ack) res_valid <= 1'b0;
            if (frame_done || tmo_hit) begin
                res_valid <= 1'b1;
                word_q    <= '0;
                if (res_valid && !res_ack) st_q <= ST_OVERRUN;
                else if (tmo_hit)          st_q <= ST_SHORT;
                else if (crc_ok) begin
                    st_q   <= ST_OK;
                    word_q <= rx_frame[FRAME_W-1:CRC_W];
                end else                   st_q <= ST_CRC_BAD;
            end
        end
    end

    assign res_status = st_q;
    assign res_word   = word_q;
endmodule

// File: rtl/crcframe_slave_chk.sv
`timescale 1ns/1ps
module crcframe_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        res_valid,
    input logic        res_ack,
    input logic [7:0]  res_status,
    input logic [31:0] res_word,
    input logic        frame_done,
    input logic        tmo_hit
);
    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ack |=> res_valid);                                   // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_ack && !frame_done && !tmo_hit |=> !res_valid);        // R1
    AST_WORD_ZERO_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_status != 8'h00 |-> res_word == 32'h0);                // R2
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        !(frame_done && tmo_hit));                                              // R6
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_status == 8'h00 || res_status == 8'h01 ||
                       res_status == 8'h03 || res_status == 8'h0B));            // R8
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid && res_word == 32'h0);                        // R10
endmodule

bind crcframe_slave crcframe_slave_chk u_chk (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_ack(res_ack),
    .res_status(res_status), .res_word(res_word),
    .frame_done(frame_done), .tmo_hit(tmo_hit)
);

// File: tb/crcframe_slave_bench.sv
`timescale 1ns/1ps
module crcframe_slave_bench;
    localparam int TMO  = 1500;
    localparam int HALF = 8;

    typedef struct packed {
        logic [31:0] m;
        logic [31:0] s;
        logic        bad;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'h12345678, 32'hA5A5A5A5, 1'b0},
        '{32'h00000000, 32'hFFFFFFFF, 1'b0},
        '{32'hFFFFFFFF, 32'h00000000, 1'b0},
        '{32'hDEADBEEF, 32'h0F1E2D3C, 1'b1},
        '{32'h80000001, 32'h13579BDF, 1'b1}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [31:0] tx_word = '0;
    logic        tx_load = 1'b0;
    logic        res_valid;
    logic [7:0]  res_status;
    logic [31:0] res_word;
    logic        res_ack = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    crcframe_slave #(.TIMEOUT_CYCLES(TMO)) u_crcframe_slave (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .tx_word(tx_word), .tx_load(tx_load), .res_valid(res_valid),
        .res_status(res_status), .res_word(res_word), .res_ack(res_ack)
    );

    function automatic logic [7:0] ref_crc(input logic [31:0] w);
        logic [7:0] c;
        c = 8'h00;
        for (int b = 3; b >= 0; b--) begin
            c = c ^ w[b*8 +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] w);
        tx_word = w; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    endtask

    task automatic spi_bits(input logic [63:0] bits, input int n, input int load_at,
                            input logic [31:0] load_val, output logic [63:0] got);
        got = '0;
        if (cs_n) begin cs_n = 1'b0; tick(HALF); end
        for (int i = 0; i < n; i++) begin
            mosi = bits[n-1-i];
            if (i == load_at) load(load_val);
            tick(HALF);
            got  = {got[62:0], miso};
            sclk = 1'b0;
            tick(HALF);
            sclk = 1'b1;
        end
        tick(HALF);
    endtask

    task automatic cs_up;
        cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic ack;
        res_ack = 1'b1; tick(1); res_ack = 1'b0;
    endtask

    task automatic good_frame(input logic [31:0] m, input int extra, output logic [63:0] got);
        logic [63:0] f;
        f = ({24'h0, m, ref_crc(m)} << extra) | 64'hA;
        spi_bits(f, 40 + extra, -1, '0, got);
        cs_up();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] got;
        logic [63:0] f;
        tick(5); rst = 1'b0; tick(2);

        chk(res_valid == 1'b0 && res_status == 8'h00 && res_word == 32'h0, "R10 reset",
            {res_valid, res_status, res_word}, 64'h0);
        chk(miso == 1'b1, "R4 idle miso", miso, 1);

        foreach (VEC[i]) begin
            load(VEC[i].s);
            f = {24'h0, VEC[i].m, ref_crc(VEC[i].m) ^ (VEC[i].bad ? 8'h5A : 8'h00)};
            spi_bits(f, 40, -1, '0, got);
            cs_up();
            chk(got[39:0] == {VEC[i].s, ref_crc(VEC[i].s)}, "R3 miso frame",
                got[39:0], {VEC[i].s, ref_crc(VEC[i].s)});
            if (VEC[i].bad)
                chk(res_valid && res_status == 8'h01 && res_word == 0, "R2 crc error",
                    {res_status, res_word}, {8'h01, 32'h0});
            else
                chk(res_valid && res_status == 8'h00 && res_word == VEC[i].m, "R1 good frame",
                    {res_status, res_word}, {8'h00, VEC[i].m});
            tick(5);
            chk(res_valid == 1'b1, "R1 valid held", res_valid, 1);
            ack();
            chk(res_valid == 1'b0, "R1 ack clears", res_valid, 0);
        end

        // R5 surplus bits with good trailer, R4 ones after bit 40
        load(32'hC3C3C3C3);
        good_frame(32'h0BADF00D, 4, got);
        chk(res_valid && res_status == 8'h00 && res_word == 32'h0BADF00D, "R5 extra bits ok",
            {res_status, res_word}, {8'h00, 32'h0BADF00D});
        chk(got[3:0] == 4'hF, "R4 ones after frame", got[3:0], 4'hF);
        ack(); tick(20);
        chk(res_valid == 1'b0, "R5 no second result", res_valid, 0);

        // R5 surplus bits with bad trailer
        f = ({24'h0, 32'h11223344, ref_crc(32'h11223344) ^ 8'h01} << 4) | 64'h5;
        spi_bits(f, 44, -1, '0, got);
        cs_up();
        chk(res_valid && res_status == 8'h01 && res_word == 0, "R5 extra bits bad crc",
            {res_status, res_word}, {8'h01, 32'h0});
        ack();

        // R6 timeout with select held low
        spi_bits(64'hFFFFF, 20, -1, '0, got);
        tick(TMO + 50);
        chk(res_valid && res_status == 8'h0B && res_word == 0, "R6 too few bits",
            {res_status, res_word}, {8'h0B, 32'h0});
        cs_up();
        ack();

        // R7 select released early
        spi_bits(64'hABCDE, 20, -1, '0, got);
        cs_up();
        tick(TMO + 50);
        chk(res_valid == 1'b0, "R7 dropped frame", res_valid, 0);
        good_frame(32'h5A5A0FF0, 0, got);
        chk(res_valid && res_status == 8'h00 && res_word == 32'h5A5A0FF0, "R7 restart at bit 0",
            {res_status, res_word}, {8'h00, 32'h5A5A0FF0});
        ack();

        // R8 overrun
        good_frame(32'h01020304, 0, got);
        good_frame(32'h05060708, 0, got);
        chk(res_valid && res_status == 8'h03 && res_word == 0, "R8 overrun",
            {res_status, res_word}, {8'h03, 32'h0});
        ack();

        // R9 load in mid-frame
        load(32'hCAFEBABE);
        f = {24'h0, 32'h99887766, ref_crc(32'h99887766)};
        spi_bits(f, 40, 20, 32'h7E57C0DE, got);
        cs_up();
        chk(got[39:0] == {32'hCAFEBABE, ref_crc(32'hCAFEBABE)}, "R9 current frame unchanged",
            got[39:0], {32'hCAFEBABE, ref_crc(32'hCAFEBABE)});
        ack();
        good_frame(32'h0, 0, got);
        chk(got[39:0] == {32'h7E57C0DE, ref_crc(32'h7E57C0DE)}, "R9 next frame",
            got[39:0], {32'h7E57C0DE, ref_crc(32'h7E57C0DE)});
        ack();
        chk(miso == 1'b1, "R4 miso high after frame", miso, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule